// File: doc/BRIEF.md
# Bi-Phase Pulse Compression Code Generator

This block shapes the baseband envelope of one coded radar pulse in each pulse-repeat period. Two shift chains of equal length advance together: one carries the polarity of every chip, the other marks which chips are transmitted at all. A reload strobe copies both programmed words into the chains at once; each later clock with the shift enable high moves both chains by one chip. A combinational encoder looks at the chip currently at the head of both chains and drives a two-wire output that means silent, 0° or 180°. These two wires steer a balanced mixer further down the transmit path.

The programmed words are `CODE_LEN` bits wide (15 by default). Each chain has one more stage than that. The extra head stage is loaded as "silent", so the cycle right after a reload is always quiet and the programmed chips follow it one per shift. Zeros enter at the tail of both chains, so once the programmed chips have left the head the output goes silent and stays silent. The number of ones in the enable word sets the burst length in chips.

Top module: `pcg_top`

## Requirements
- R1: While `rst_n` is low, and after it is released with no reload yet, both `drv_zero` and `drv_pi` are 0.
- R2: In the cycle after a reload, both outputs are 0. After the k-th following shift (k = 1..CODE_LEN), the outputs show chip k-1 of the programmed words, where bit k-1 of `cfg_enable` and bit k-1 of `cfg_phase` give that chip.
- R3: A reload captures `cfg_enable` and `cfg_phase` into both chains on the same edge. When `reload` and `shift_en` are high together, the reload wins.
- R4: With `shift_en` high and `reload` low, both chains advance by exactly one chip per clock. With both controls low, the outputs hold their value.
- R5: An enable bit of 0 gives `drv_zero`=0 and `drv_pi`=0, whatever the phase bit is.
- R6: An enable bit of 1 with phase bit 0 gives `drv_zero`=1 and `drv_pi`=0. An enable bit of 1 with phase bit 1 gives `drv_zero`=0 and `drv_pi`=1.
- R7: `drv_zero` and `drv_pi` are never both 1.
- R8: Zeros fill both chains from the tail. After more than CODE_LEN shifts following a reload, the output is silent. Over a full burst, the number of active chips equals the number of ones in `cfg_enable`.
- R9: Changing `cfg_enable` or `cfg_phase` without a reload has no effect on the chips still in flight.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Chip clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reload | input | 1 | Parallel load of both chains from the configuration words |
| shift_en | input | 1 | Advance both chains by one chip |
| cfg_phase | input | CODE_LEN | Polarity per chip; bit i is chip i, 1 means 180° |
| cfg_enable | input | CODE_LEN | Transmit mask per chip; bit i is chip i, 1 means active |
| drv_zero | output | 1 | Mixer drive for 0° |
| drv_pi | output | 1 | Mixer drive for 180° |

## Verification
The assertions assume that `reload` and `shift_en` are synchronous to `clk` and settled before each rising edge. They also assume the configuration words are stable on any edge where `reload` is high. The properties do not require the words to stay stable between reloads, since R9 allows them to change. The bench changes every input only on the falling clock edge. It also deliberately changes the configuration words in the middle of a burst and raises both controls together, so that the cases the properties must tolerate are actually exercised.

// File: rtl/pcg_pkg.sv
package pcg_pkg;

  // Two-wire mixer drive; the 2'b11 pattern is never produced.
  typedef enum logic [1:0] {
    DRV_OFF  = 2'b00,
    DRV_ZERO = 2'b01,
    DRV_PI   = 2'b10
  } drive_e;

  // Head stage contents written on every reload (start-of-pulse slot).
  localparam logic HEAD_ENABLE = 1'b0;
  localparam logic HEAD_PHASE  = 1'b0;

  // Value shifted in at the tail of each chain.
  localparam logic TAIL_FILL = 1'b0;

endpackage

// File: rtl/pcg_shift_chain.sv
module pcg_shift_chain #(
  parameter int STAGES = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              advance,
  input  logic [STAGES-1:0] par_in,
  input  logic              fill,
  output logic              head
);

  logic [STAGES-1:0] stage_q;
  logic [STAGES-1:0] stage_d;
  logic              stage_en;

  // next-state: load has priority over advance
  always_comb begin
    stage_en = load | advance;
    if (load) begin
      stage_d = par_in;
    end else begin
      stage_d = {fill, stage_q[STAGES-1:1]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
    end else if (stage_en) begin
      stage_q <= stage_d;
    end
  end

  assign head = stage_q[0];

  AST_LOAD_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (stage_q == $past(par_in)));                               // R3

  AST_ADVANCE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !load) |=> ((stage_q[STAGES-2:0] == $past(stage_q[STAGES-1:1]))
                            && (stage_q[STAGES-1] == $past(fill))));    // R4

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!advance && !load) |=> $stable(stage_q));                          // R4

endmodule

// File: rtl/pcg_encoder.sv
module pcg_encoder
  import pcg_pkg::*;
(
  input  logic   enable_bit,
  input  logic   phase_bit,
  output drive_e drive
);

  always_comb begin
    if (!enable_bit) begin
      drive = DRV_OFF;
    end else if (phase_bit) begin
      drive = DRV_PI;
    end else begin
      drive = DRV_ZERO;
    end
  end

endmodule

// File: rtl/pcg_top.sv
module pcg_top
  import pcg_pkg::*;
#(
  parameter int CODE_LEN = 15
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reload,
  input  logic                shift_en,
  input  logic [CODE_LEN-1:0] cfg_phase,
  input  logic [CODE_LEN-1:0] cfg_enable,
  output logic                drv_zero,
  output logic                drv_pi
);

  localparam int STAGES   = CODE_LEN + 1;
  localparam int N_CHAINS = 2;
  localparam int IDX_EN   = 0;
  localparam int IDX_PH   = 1;

  logic [N_CHAINS-1:0][STAGES-1:0] chain_load;
  logic [N_CHAINS-1:0]             chain_head;
  drive_e                          drive;

  assign chain_load[IDX_EN] = {cfg_enable, HEAD_ENABLE};
  assign chain_load[IDX_PH] = {cfg_phase,  HEAD_PHASE};

  // both chains share load/advance so they stay in lockstep
  for (genvar g = 0; g < N_CHAINS; g++) begin : g_chain
    pcg_shift_chain #(
      .STAGES (STAGES)
    ) u_chain (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (reload),
      .advance (shift_en),
      .par_in  (chain_load[g]),
      .fill    (TAIL_FILL),
      .head    (chain_head[g])
    );
  end

  pcg_encoder u_enc (
    .enable_bit (chain_head[IDX_EN]),
    .phase_bit  (chain_head[IDX_PH]),
    .drive      (drive)
  );

  assign drv_zero = (drive == DRV_ZERO);
  assign drv_pi   = (drive == DRV_PI);

  AST_SILENT_AFTER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    reload |=> (!drv_zero && !drv_pi));                                 // R2

  AST_FIRST_CHIP: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_en && !reload && $past(reload)) |=>
      ((drv_zero || drv_pi) == $past(cfg_enable[0], 2)));               // R2

endmodule

// File: tb/pcg_top_bench.sv
`timescale 1ns/1ps
module pcg_top_bench;

  localparam int CODE_LEN = 15;

  logic                clk;
  logic                rst_n;
  logic                reload;
  logic                shift_en;
  logic [CODE_LEN-1:0] cfg_phase;
  logic [CODE_LEN-1:0] cfg_enable;
  logic                drv_zero;
  logic                drv_pi;

  int n_tests;
  int n_fail;
  bit done;

  bit q_en[$];
  bit q_ph[$];

  pcg_top #(.CODE_LEN(CODE_LEN)) u_pcg_top (
    .clk        (clk),
    .rst_n      (rst_n),
    .reload     (reload),
    .shift_en   (shift_en),
    .cfg_phase  (cfg_phase),
    .cfg_enable (cfg_enable),
    .drv_zero   (drv_zero),
    .drv_pi     (drv_pi)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic model_clear();
    q_en.delete();
    q_ph.delete();
    for (int i = 0; i <= CODE_LEN; i++) begin
      q_en.push_back(1'b0);
      q_ph.push_back(1'b0);
    end
  endtask

  task automatic model_edge(input logic rl, input logic sh);
    if (rl) begin
      q_en.delete();
      q_ph.delete();
      q_en.push_back(1'b0);
      q_ph.push_back(1'b0);
      for (int i = 0; i < CODE_LEN; i++) begin
        q_en.push_back(cfg_enable[i]);
        q_ph.push_back(cfg_phase[i]);
      end
    end else if (sh) begin
      void'(q_en.pop_front());
      void'(q_ph.pop_front());
      q_en.push_back(1'b0);
      q_ph.push_back(1'b0);
    end
  endtask

  task automatic compare(input string req);
    logic exp_z;
    logic exp_p;
    exp_z = q_en[0] & ~q_ph[0];
    exp_p = q_en[0] &  q_ph[0];
    n_tests++;
    if (drv_zero !== exp_z || drv_pi !== exp_p) begin
      n_fail++;
      $display("FAIL %s: {zero,pi} actual %b%b expected %b%b at %0t",
               req, drv_zero, drv_pi, exp_z, exp_p, $time);
    end
    n_tests++;
    if (drv_zero === 1'b1 && drv_pi === 1'b1) begin
      n_fail++;
      $display("FAIL R7: {zero,pi} actual 11 expected not 11 at %0t", $time);
    end
  endtask

  task automatic step(input logic rl, input logic sh, input string req);
    reload   = rl;
    shift_en = sh;
    @(posedge clk);
    model_edge(rl, sh);
    @(negedge clk);
    compare(req);
  endtask

  task automatic burst(input logic [CODE_LEN-1:0] en, input logic [CODE_LEN-1:0] ph,
                       input string req);
    int active;
    cfg_enable = en;
    cfg_phase  = ph;
    step(1'b1, 1'b0, "R2");
    active = 0;
    for (int k = 0; k < CODE_LEN + 4; k++) begin
      step(1'b0, 1'b1, req);
      if (drv_zero || drv_pi) active++;
    end
    n_tests++;
    if (active != $countones(en)) begin
      n_fail++;
      $display("FAIL R8: active chips actual %0d expected %0d", active, $countones(en));
    end
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: run actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [CODE_LEN-1:0] code_ph;
    n_tests    = 0;
    n_fail     = 0;
    done       = 1'b0;
    rst_n      = 1'b0;
    reload     = 1'b0;
    shift_en   = 1'b0;
    cfg_phase  = '0;
    cfg_enable = '0;
    model_clear();
    repeat (2) @(negedge clk);
    compare("R1");
    rst_n = 1'b1;
    step(1'b0, 1'b1, "R1");
    step(1'b0, 1'b0, "R1");

    // single-chip pulse, both polarities (R6, R2)
    burst(15'h0001, 15'h0000, "R6");
    burst(15'h0001, 15'h0001, "R6");

    // full code: + + + + - - - + - - + + - + -  (chip i in bit i, - is 1)
    code_ph = 15'b101_0011_0111_0000;
    burst(15'h7FFF, code_ph, "R2");

    // mask zero with phase ones stays silent (R5)
    burst(15'h0000, 15'h7FFF, "R5");
    burst(15'h5555, 15'h7FFF, "R5");

    // random partial masks
    for (int t = 0; t < 6; t++) begin
      burst(15'($urandom), 15'($urandom), "R8");
    end

    // hold without shift (R4)
    cfg_enable = 15'h7FFF;
    cfg_phase  = 15'h2AAA;
    step(1'b1, 1'b0, "R3");
    step(1'b0, 1'b1, "R4");
    step(1'b0, 1'b1, "R4");
    for (int k = 0; k < 5; k++) step(1'b0, 1'b0, "R4");

    // config changes mid-burst without reload (R9)
    cfg_enable = 15'h0000;
    cfg_phase  = 15'h7FFF;
    for (int k = 0; k < 6; k++) step(1'b0, 1'b1, "R9");

    // reload together with shift: reload wins (R3)
    cfg_enable = 15'h7FFF;
    cfg_phase  = 15'h0000;
    step(1'b1, 1'b1, "R3");
    step(1'b0, 1'b1, "R3");
    step(1'b1, 1'b1, "R3");
    for (int k = 0; k < CODE_LEN + 3; k++) step(1'b0, 1'b1, "R8");

    // reset mid-burst returns to silent (R1)
    step(1'b1, 1'b0, "R2");
    step(1'b0, 1'b1, "R6");
    rst_n = 1'b0;
    model_clear();
    @(negedge clk);
    compare("R1");
    rst_n = 1'b1;
    step(1'b0, 1'b1, "R1");

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule